// File: doc/BRIEF.md
# Parallel NOR Flash Byte-Program and Sector-Erase Sequencer

This block turns one host request into the complete bus conversation that a parallel NOR flash device needs in order to change its contents. A request carries a target address, a data byte and a flag that selects a byte program or a sector erase. The sequencer writes the fixed unlock preamble that the device expects, then the payload cycle. After that it reads the target location repeatedly until the device reports that the internal operation has finished, and it ends with a one-cycle completion pulse that may carry an error flag.

The flash side is a simple asynchronous-style bus: an address, separate write and read data buses, and active-low chip enable, write enable and output enable. Every strobe is timed in whole clocks. The host side is a valid/ready handshake. The ready signal stays low from acceptance until completion, because the device cannot serve normal reads while it is busy.

Completion uses data polling. Bit 7 of the polled byte shows the complement of the expected value until the device is done. Bit 5 marks an internal fault, and that case gets exactly one confirming re-read. A programmable clock budget bounds the wait.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `error` are 0, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are all 1.
- R2: A program request (`req_erase`=0) produces exactly four bus writes, in this order: 0xAA to address 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then `req_data` to `req_addr`.
- R3: An erase request (`req_erase`=1) produces exactly six bus writes, in this order: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 to `req_addr` (the sector address).
- R4: Each write holds `fl_we_n` low for exactly WE_CLKS consecutive clocks, only while `fl_ce_n` is low. `fl_addr` and `fl_wdata` stay stable for the whole low phase, and `fl_ce_n` returns high for at least one clock between bus cycles.
- R5: `fl_we_n` and `fl_oe_n` are never both low in the same clock.
- R6: `req_ready` is low from the cycle after a request is accepted until after `done`. Requests presented during that time cause no bus activity.
- R7: After the last write, the block reads `req_addr`. It signals `done` with `error`=0 only once bit 7 of the read data equals the expected value (bit 7 of `req_data` for a program, 1 for an erase).
- R8: If a poll read shows bit 5 set while bit 7 still mismatches, exactly one more read is made. A match on that read ends without error; a mismatch ends with `error`=1.
- R9: If `cfg_timeout` clocks of polling elapse without a match or a fault indication, the operation ends with `error`=1. A device that finishes inside the budget ends without error.
- R10: `done` is a single-cycle pulse, and `error` is high only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_erase | input | 1 | 1 = sector erase, 0 = byte program |
| req_addr | input | ADDR_W | Target byte address, or the sector address for an erase |
| req_data | input | DATA_W | Byte to program |
| cfg_timeout | input | TMO_W | Polling budget in clocks |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure indication, valid with `done` |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | DATA_W | Flash write data |
| fl_rdata | input | DATA_W | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The assertions assume that reset is held for at least one clock at start-up and that `fl_rdata` is only meaningful during a read strobe; they place no demand on the host's request timing. The bench honours this by holding reset for several clocks. Its flash model drives read data from its own busy/fault state, which changes only on falling clock edges, so every captured poll byte is stable. The bench deliberately keeps `req_valid` high with altered fields during an operation to show that such input is ignored, not forbidden.

// File: rtl/flash_seq_pkg.sv
// Shared types and the command-cycle table for the flash sequencer.
// Assumes the unlock addresses fit in 12 bits and the top ADDR_W >= 12.
package flash_seq_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_STROBE,
        BUS_HOLD
    } bus_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD_GO,
        SQ_CMD_WAIT,
        SQ_POLL_GO,
        SQ_POLL_WAIT,
        SQ_CHK_GO,
        SQ_CHK_WAIT,
        SQ_FINISH
    } seq_state_e;

    localparam logic [11:0] UNLOCK_HI = 12'h555;
    localparam logic [11:0] UNLOCK_LO = 12'h2AA;

    typedef struct packed {
        logic [11:0] addr;     // fixed command address
        logic [7:0]  data;     // fixed command byte
        logic        use_tgt;  // take the request address instead
        logic        use_usr;  // take the request data instead
        logic        last;     // final write of the sequence
    } cmd_word_t;

    // Look up one write of the program or erase sequence.
    function automatic cmd_word_t cmd_lookup(input logic erase, input logic [2:0] step);
        cmd_word_t w;
        w = '0;
        case ({erase, step})
            4'b0_000: begin w.addr = UNLOCK_HI; w.data = 8'hAA; end
            4'b0_001: begin w.addr = UNLOCK_LO; w.data = 8'h55; end
            4'b0_010: begin w.addr = UNLOCK_HI; w.data = 8'hA0; end
            4'b0_011: begin w.use_tgt = 1'b1; w.use_usr = 1'b1; w.last = 1'b1; end
            4'b1_000: begin w.addr = UNLOCK_HI; w.data = 8'hAA; end
            4'b1_001: begin w.addr = UNLOCK_LO; w.data = 8'h55; end
            4'b1_010: begin w.addr = UNLOCK_HI; w.data = 8'h80; end
            4'b1_011: begin w.addr = UNLOCK_HI; w.data = 8'hAA; end
            4'b1_100: begin w.addr = UNLOCK_LO; w.data = 8'h55; end
            4'b1_101: begin w.use_tgt = 1'b1; w.data = 8'h30; w.last = 1'b1; end
            default:  w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fseq_cmd_gen.sv
// Command generator: maps the current step of a program or erase sequence
// to the address and data of the bus write. Purely combinational.
// Assumes step stays inside the sequence length of the selected command.
module fseq_cmd_gen
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              is_erase,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] usr_data,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_last
);

    cmd_word_t cw;

    // Fetch the table entry for this step.
    always_comb cw = cmd_lookup(is_erase, step);

    // Substitute request fields where the table asks for them.
    always_comb begin
        cmd_addr = cw.use_tgt ? tgt_addr : ADDR_W'(cw.addr);
        cmd_data = cw.use_usr ? usr_data : DATA_W'(cw.data);
        cmd_last = cw.last;
    end

endmodule

// File: rtl/fseq_bus_engine.sv
// Bus engine: runs one flash bus cycle (write or read) per start pulse.
// A cycle is SETUP (chip enabled, strobes high), STROBE (WE_CLKS or
// RD_CLKS clocks with the selected strobe low), HOLD (strobes high), then
// a done pulse while idle with the chip deselected. Read data is captured
// on the last strobe clock. Assumes start only arrives while idle.
module fseq_bus_engine
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int WE_CLKS = 3,
    parameter int RD_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    localparam int MAX_CLKS = (WE_CLKS > RD_CLKS) ? WE_CLKS : RD_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    bus_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Step through the phases of one bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BUS_IDLE;
            cnt    <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rdata  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                BUS_IDLE: begin
                    if (start) begin
                        st     <= BUS_SETUP;
                        addr_q <= addr;
                        data_q <= wdata;
                        rd_q   <= is_read;
                    end
                end
                BUS_SETUP: begin
                    st  <= BUS_STROBE;
                    cnt <= rd_q ? CNT_W'(RD_CLKS - 1) : CNT_W'(WE_CLKS - 1);
                end
                BUS_STROBE: begin
                    if (cnt == '0) begin
                        st <= BUS_HOLD;
                        if (rd_q) rdata <= fl_rdata;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BUS_HOLD: begin
                    st   <= BUS_IDLE;
                    done <= 1'b1;
                end
                default: st <= BUS_IDLE;
            endcase
        end
    end

    // Drive the flash pins from the phase register.
    always_comb begin
        fl_addr  = addr_q;
        fl_wdata = data_q;
        fl_ce_n  = (st == BUS_IDLE);
        fl_we_n  = !((st == BUS_STROBE) && !rd_q);
        fl_oe_n  = !((st == BUS_STROBE) && rd_q);
    end

endmodule

// File: rtl/fseq_poll_eval.sv
// Poll evaluator: judges a polled byte (completion bit and fault bit) and
// counts clocks spent polling against a programmable budget.
// Assumes clear is held while commands are issued and run while polling.
module fseq_poll_eval #(
    parameter int DATA_W = 8,
    parameter int TMO_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [TMO_W-1:0]  limit,
    input  logic [DATA_W-1:0] rdata,
    input  logic              expect_hi,
    output logic              match,
    output logic              fault,
    output logic              expired
);

    localparam int DONE_BIT  = DATA_W - 1;
    localparam int FAULT_BIT = DATA_W - 3;

    logic [TMO_W-1:0] elapsed;
    logic             unused_bits;

    // Count polling clocks, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            elapsed <= '0;
        end else if (run && (elapsed != '1)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Decode the status bits of the captured byte.
    always_comb begin
        match       = (rdata[DONE_BIT] == expect_hi);
        fault       = rdata[FAULT_BIT];
        expired     = (elapsed >= limit);
        unused_bits = ^rdata;
    end

endmodule

// File: rtl/flash_prog_seq.sv
// Flash program/erase sequencer top. Accepts one request, issues the
// unlock preamble and payload write through the bus engine, then polls the
// target address until completion, fault or timeout, and pulses done.
// Assumes a single flash device and a host that waits for req_ready.
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int WE_CLKS = 3,
    parameter int RD_CLKS = 2,
    parameter int TMO_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TMO_W-1:0]  cfg_timeout,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    seq_state_e        st;
    logic [2:0]        step;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] usr_data;
    logic              is_erase;
    logic              err_q;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;
    logic              bus_start;
    logic              bus_read;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_done;
    logic [DATA_W-1:0] bus_rdata;
    logic              p_match;
    logic              p_fault;
    logic              p_expired;
    logic              p_clear;
    logic              p_run;
    logic              exp_hi;

    fseq_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .is_erase (is_erase),
        .step     (step),
        .tgt_addr (tgt_addr),
        .usr_data (usr_data),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .cmd_last (cmd_last)
    );

    fseq_bus_engine #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .WE_CLKS(WE_CLKS), .RD_CLKS(RD_CLKS)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (bus_start),
        .is_read  (bus_read),
        .addr     (bus_addr),
        .wdata    (cmd_data),
        .done     (bus_done),
        .rdata    (bus_rdata),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .fl_rdata (fl_rdata),
        .fl_ce_n  (fl_ce_n),
        .fl_we_n  (fl_we_n),
        .fl_oe_n  (fl_oe_n)
    );

    fseq_poll_eval #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (p_clear),
        .run       (p_run),
        .limit     (cfg_timeout),
        .rdata     (bus_rdata),
        .expect_hi (exp_hi),
        .match     (p_match),
        .fault     (p_fault),
        .expired   (p_expired)
    );

    // Main sequence: accept, command writes, polling, confirm, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            step     <= '0;
            tgt_addr <= '0;
            usr_data <= '0;
            is_erase <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        tgt_addr <= req_addr;
                        usr_data <= req_data;
                        is_erase <= req_erase;
                        step     <= '0;
                        err_q    <= 1'b0;
                        st       <= SQ_CMD_GO;
                    end
                end
                SQ_CMD_GO:  st <= SQ_CMD_WAIT;
                SQ_CMD_WAIT: begin
                    if (bus_done) begin
                        if (cmd_last) begin
                            st <= SQ_POLL_GO;
                        end else begin
                            step <= 3'(step + 1'b1);
                            st   <= SQ_CMD_GO;
                        end
                    end
                end
                SQ_POLL_GO: st <= SQ_POLL_WAIT;
                SQ_POLL_WAIT: begin
                    if (bus_done) begin
                        if (p_match) begin
                            st <= SQ_FINISH;
                        end else if (p_fault) begin
                            st <= SQ_CHK_GO;
                        end else if (p_expired) begin
                            err_q <= 1'b1;
                            st    <= SQ_FINISH;
                        end else begin
                            st <= SQ_POLL_GO;
                        end
                    end
                end
                SQ_CHK_GO: st <= SQ_CHK_WAIT;
                SQ_CHK_WAIT: begin
                    if (bus_done) begin
                        err_q <= !p_match;
                        st    <= SQ_FINISH;
                    end
                end
                SQ_FINISH: st <= SQ_IDLE;
                default:   st <= SQ_IDLE;
            endcase
        end
    end

    // Decode bus requests, poll control and host-facing outputs.
    always_comb begin
        bus_start = (st == SQ_CMD_GO) || (st == SQ_POLL_GO) || (st == SQ_CHK_GO);
        bus_read  = (st != SQ_CMD_GO);
        bus_addr  = (st == SQ_CMD_GO) ? cmd_addr : tgt_addr;
        p_clear   = (st == SQ_CMD_WAIT);
        p_run     = (st == SQ_POLL_GO) || (st == SQ_POLL_WAIT) ||
                    (st == SQ_CHK_GO)  || (st == SQ_CHK_WAIT);
        exp_hi    = is_erase ? 1'b1 : usr_data[DATA_W-1];
        req_ready = (st == SQ_IDLE);
        done      = (st == SQ_FINISH);
        error     = done && err_q;
    end

endmodule

// File: rtl/flash_prog_seq_chk.sv
// Protocol checker for the sequencer, bound to every instance of the top.
// Assumes reset is asserted for at least one clock at start-up.
module flash_prog_seq_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              error,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              fl_ce_n,
    input logic              fl_we_n,
    input logic              fl_oe_n
);

    a_r5_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);

    a_r4_stable_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    a_r4_deselect_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_ce_n) |=> fl_ce_n);

    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r6_not_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_prog_seq_test.sv
// Bench: behavioural flash model plus a sweep of program requests, erase,
// fault and timeout cases. Expected bus traffic is computed here.
module flash_prog_seq_test;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 8;
    localparam int WE_CLKS = 3;
    localparam int RD_CLKS = 2;
    localparam int TMO_W   = 16;
    localparam int POLL_P  = RD_CLKS + 4;   // clocks between captured polls
    localparam int F_DLY   = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_erase = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [TMO_W-1:0]  cfg_timeout = '0;
    logic              done, error;
    logic [ADDR_W-1:0] fl_addr;
    logic [DATA_W-1:0] fl_wdata;
    logic [DATA_W-1:0] fl_rdata;
    logic              fl_ce_n, fl_we_n, fl_oe_n;

    flash_prog_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_CLKS(WE_CLKS),
        .RD_CLKS(RD_CLKS), .TMO_W(TMO_W)
    ) uut (.*);

    int n_tests = 0;
    int n_fail  = 0;

    // Flash model state
    logic [7:0]        mem [4096];
    logic [ADDR_W-1:0] log_a [8];
    logic [7:0]        log_d [8];
    int wr_cnt = 0, m_nwr = 4, m_mode = 0, m_busy_len = 0, age = 0, reads_f = 0, we_w = 0;
    bit busy = 0, m_erase = 0, last_f = 0, f_now;
    bit prev_we = 1, prev_oe = 1, prev_done = 0, in_op = 0;
    logic [ADDR_W-1:0] m_tgt = '0, we_a = '0;
    logic [7:0] m_data = '0, we_d = '0;
    int viol_overlap = 0, viol_strobe = 0, viol_ready = 0, viol_done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Model read data: status while busy, array contents otherwise.
    always_comb begin
        f_now = 1'b0;
        if (busy && m_mode == 1 && age >= 5) f_now = 1'b1;
        if (busy && m_mode == 2 && age >= F_DLY && age < F_DLY + POLL_P) f_now = 1'b1;
        if (busy) fl_rdata = {~(m_erase | m_data[7]), 1'b0, f_now, 5'b0};
        else      fl_rdata = mem[fl_addr];
    end

    // Model and monitors, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n && !fl_oe_n) viol_overlap++;
            if (error && !done) viol_done++;
            if (done && prev_done) viol_done++;
            if (in_op && req_ready) viol_ready++;
            if (!fl_we_n) begin
                if (prev_we) begin
                    we_w = 1; we_a = fl_addr; we_d = fl_wdata;
                end else begin
                    we_w++;
                    if (fl_addr != we_a || fl_wdata != we_d) viol_strobe++;
                end
            end else if (!prev_we) begin
                if (we_w != WE_CLKS) viol_strobe++;
                if (wr_cnt < 8) begin log_a[wr_cnt] = we_a; log_d[wr_cnt] = we_d; end
                wr_cnt++;
                if (wr_cnt == m_nwr) begin busy = 1; age = 0; end
            end
            if (!fl_oe_n) last_f = f_now;
            else if (!prev_oe && last_f) reads_f++;
            if (busy) begin
                age++;
                if ((m_mode == 0 && age >= m_busy_len) ||
                    (m_mode == 2 && age >= F_DLY + POLL_P)) begin
                    busy = 0;
                    if (m_erase) begin
                        for (int j = 0; j < 256; j++) mem[{m_tgt[11:8], 8'(j)}] = 8'hFF;
                    end else begin
                        mem[m_tgt] = mem[m_tgt] & m_data;
                    end
                end
            end
        end
        prev_we = fl_we_n; prev_oe = fl_oe_n; prev_done = done;
    end

    // Run one request and check bus traffic and outcome.
    task automatic run_op(input bit er, input int addr, input int data, input int mode,
                          input int blen, input int tmo, input bit exp_err,
                          input string tag, input bit spam);
        logic [11:0] ea [6];
        logic [7:0]  ed [6];
        int cyc;
        bit got_done, got_err;
        @(negedge clk);
        wr_cnt = 0; reads_f = 0; busy = 0; age = 0;
        m_nwr = er ? 6 : 4; m_mode = mode; m_busy_len = blen; m_erase = er;
        m_tgt = ADDR_W'(addr); m_data = 8'(data);
        cfg_timeout = TMO_W'(tmo);
        req_valid = 1; req_erase = er; req_addr = ADDR_W'(addr); req_data = 8'(data);
        @(negedge clk);
        in_op = 1;
        if (spam) begin
            req_addr = ~req_addr; req_data = ~req_data; req_erase = !er;
        end else begin
            req_valid = 0;
        end
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        got_done = done; got_err = error;
        in_op = 0; req_valid = 0;
        if (er) begin
            ea = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'(addr)};
            ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
        end else begin
            ea = '{12'h555, 12'h2AA, 12'h555, 12'(addr), 12'h0, 12'h0};
            ed = '{8'hAA, 8'h55, 8'hA0, 8'(data), 8'h0, 8'h0};
        end
        check(got_done, {tag, " done seen"}, got_done, 1);
        check(got_err == exp_err, {tag, " error flag"}, got_err, exp_err);
        check(wr_cnt == m_nwr, {tag, " write count"}, wr_cnt, m_nwr);
        for (int k = 0; k < m_nwr; k++) begin
            if (log_a[k] != ea[k] || log_d[k] != ed[k]) begin
                check(0, {tag, " write addr/data"}, {log_a[k], log_d[k]}, {ea[k], ed[k]});
            end
        end
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL R6 watchdog: actual run unfinished, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int j = 0; j < 4096; j++) mem[j] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1 && done == 0 && error == 0, "R1 idle outputs", {req_ready, done, error}, 3'b100);
        check(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes high", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);

        // R2 R7 sweep over every byte value at distinct addresses
        for (int i = 0; i < 256; i++) begin
            int a;
            a = i * 16 + (i % 16);
            run_op(0, a, i, 0, (i % 7) * 3, 500, 0, "R2/R7 program", 0);
            check(busy == 0, "R7 done only after device finished", busy, 0);
            check(mem[a] == 8'(i), "R7 byte stored", mem[a], i);
        end

        // R3 erase sector 3, sector 2 must keep its data
        run_op(1, 12'h3A7, 8'h00, 0, 25, 500, 0, "R3 erase", 0);
        begin
            int bad = 0;
            for (int j = 0; j < 256; j++) if (mem[12'h300 + j] != 8'hFF) bad++;
            check(bad == 0, "R3 sector erased", bad, 0);
        end
        check(mem[32 * 16] == 8'd32, "R3 other sector kept", mem[32 * 16], 32);

        // R8 fault that persists: one confirming read then error
        run_op(0, 12'h305, 8'h12, 1, 0, 2000, 1, "R8 fault persists", 0);
        check(reads_f == 2, "R8 exactly one re-read", reads_f, 2);
        // R8 fault seen, device finishes before the re-read
        run_op(0, 12'h306, 8'h9C, 2, 0, 2000, 0, "R8 fault then recovery", 0);
        check(reads_f == 1, "R8 single fault read", reads_f, 1);
        check(mem[12'h306] == 8'h9C, "R8 byte stored", mem[12'h306], 8'h9C);

        // R9 device never finishes: budget expires
        run_op(0, 12'h307, 8'h40, 3, 0, 40, 1, "R9 timeout", 0);
        check(busy == 1, "R9 still busy at error", busy, 1);
        // R9 slow device inside budget
        run_op(0, 12'h308, 8'h81, 0, 60, 200, 0, "R9 inside budget", 0);
        check(mem[12'h308] == 8'h81, "R9 byte stored", mem[12'h308], 8'h81);

        // R6 requests held during an operation are ignored
        run_op(0, 12'h309, 8'h5A, 0, 9, 500, 0, "R6 held request", 1);
        repeat (30) @(negedge clk);
        check(wr_cnt == 4, "R6 no extra writes after done", wr_cnt, 4);
        check(req_ready == 1, "R6 ready again", req_ready, 1);

        // R4 R5 R6 R10 monitor totals
        check(viol_strobe == 0, "R4 strobe width/stability", viol_strobe, 0);
        check(viol_overlap == 0, "R5 OE/WE overlap", viol_overlap, 0);
        check(viol_ready == 0, "R6 ready during operation", viol_ready, 0);
        check(viol_done == 0, "R10 done/error pulse", viol_done, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule